// File: doc/BRIEF.md
# Ping-Pong Descriptor DMA Channel

This block is a single DMA channel that owns two complete descriptor sets, each made of a start address, a beat count and a command word. At any time one set is the active member and the other is the standby member. The hardware works through the active member while software fills in the standby one. When the active member has moved its programmed number of words, it disarms itself and raises its own done flag. If the standby member is armed, the channel then turns it into the active member. Each set runs only once per arming and never loops back to its start.

Software reaches the descriptors and a separate control word over a small word-addressed register bus with combinational read data. On the memory side the channel issues one request at a time with an address and a write enable, and holds it until the memory acknowledges it. Each acknowledged beat also produces a one-cycle strobe towards the peripheral FIFO. The transfer direction is fixed for each instance by a parameter. In the default direction, data moves from the peripheral into memory. In the other direction, memory read data is passed to the peripheral with a push strobe.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, every register reads zero, set 0 is the active member, no memory request is raised and the interrupt output is low.
- R2: Register map by byte offset. Set 0 sits at 0x00 (address), 0x04 (length in words) and 0x08 (command). Set 1 sits 0x10 above, at 0x10, 0x14 and 0x18. The control word is at 0x20. Command bit 0 is the start/armed bit. A written value reads back unchanged while the set is not running.
- R3: While the active set is armed, its length is non-zero and per_ready is high, the channel raises mem_req with mem_addr equal to the set's current address. It holds both stable until mem_ack.
- R4: Each acknowledged beat adds DATA_W/8 to the active set's address and subtracts one from its length.
- R5: In the default peripheral-to-memory direction, mem_we is 1 and mem_wdata carries per_rdata. per_pop pulses for exactly the cycle in which the beat is acknowledged.
- R6: When the active set's length is zero and no beat is outstanding, the set's start bit clears and its done flag is set. No further request is made from that set.
- R7: When the active set is not armed and the other set is armed, the other set becomes active. Control bit 0 reports the active set (0 or 1). Sets run in the order in which they become active.
- R8: A write to any register of the active set while that set is armed has no effect.
- R9: Control bits 1 and 2 are the done flags of set 0 and set 1. Writing 1 to a done bit clears it, and writing 0 leaves it unchanged. Control bit 3 is the interrupt enable. irq equals the enable ANDed with the OR of the two done flags, and it stays high until software clears the flags.
- R10: Arming a set whose length is zero completes it with no memory request. Its done flag is set and its start bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset (word aligned) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 for a memory write, 0 for a memory read |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_ack | input | 1 | Memory acknowledge, completes the beat |
| mem_rdata | input | DATA_W | Read data from memory |
| per_ready | input | 1 | Peripheral FIFO has data or space for a beat |
| per_rdata | input | DATA_W | Head word of the peripheral FIFO |
| per_pop | output | 1 | Pop strobe to the peripheral FIFO |
| per_wdata | output | DATA_W | Word pushed into the peripheral FIFO |
| per_push | output | 1 | Push strobe to the peripheral FIFO |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker watches four properties on every cycle: a request stays stable until it is acknowledged, each acknowledged beat advances the address by one word, requests come only from an armed active set, and the active member changes only when no beat is outstanding. It also checks that irq cannot drop without a control write. The directed scenarios are the only way to show the rest: beats are ordered across the two sets in ping-pong order, writes to a running set leave the register contents unchanged, zero-length descriptors complete without a request, and each done flag is cleared selectively by writing 1 to its bit.

// File: rtl/pp_dma_pkg.sv
// Shared field codes and bit positions for the ping-pong DMA channel.
package pp_dma_pkg;
    // Register field selected by byte offset bits [3:2] within a block
    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_LEN  = 2'd1,
        FLD_CMD  = 2'd2,
        FLD_RSV  = 2'd3
    } fld_e;

    // Block selected by byte offset bits [5:4]
    localparam logic [1:0] BLK_SET0 = 2'd0;
    localparam logic [1:0] BLK_SET1 = 2'd1;
    localparam logic [1:0] BLK_CTRL = 2'd2;

    localparam int CMD_START_BIT  = 0;
    localparam int CTRL_ACT_BIT   = 0;
    localparam int CTRL_DONE0_BIT = 1;
    localparam int CTRL_DONE1_BIT = 2;
    localparam int CTRL_IE_BIT    = 3;
endpackage

// File: rtl/pp_dma_desc.sv
// One descriptor set: address, remaining length and armed bit.
// Assumes the parent never asserts wr_en and beat_done together for the
// same set (writes to a running set are filtered upstream).
module pp_dma_desc
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int REG_W  = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  fld_e              wr_fld,
    input  logic [REG_W-1:0]  wdata,
    input  logic              beat_done,
    input  logic              clr_arm,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_len,
    output logic              armed
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Descriptor state: software loads, beats advance, completion disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_len  <= '0;
            armed    <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_fld)
                    FLD_ADDR: cur_addr <= wdata[ADDR_W-1:0];
                    FLD_LEN:  cur_len  <= wdata[LEN_W-1:0];
                    FLD_CMD:  armed    <= wdata[CMD_START_BIT];
                    default:  ;
                endcase
            end
            if (beat_done) begin
                cur_addr <= cur_addr + STEP_V;
                cur_len  <= cur_len - 1'b1;
            end
            if (clr_arm) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pp_dma_engine.sv
// Beat sequencer and active-set selector. Issues one memory beat at a time
// from the active set, completes a set when its length is zero, and hands
// control to the other set when the active one is idle and the other armed.
// Assumes mem_ack is only meaningful while a request is pending.
module pp_dma_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] armed,
    input  logic [1:0] len_zero,
    input  logic       per_ready,
    input  logic       mem_ack,
    output logic       act,
    output logic       pending,
    output logic       ack_fire,
    output logic [1:0] beat_done,
    output logic [1:0] complete
);
    logic busy;
    logic finish;
    logic swap;

    // Decode of the active set's condition for this cycle
    always_comb begin
        busy     = armed[act] && !len_zero[act];
        ack_fire = pending && mem_ack;
        finish   = armed[act] && len_zero[act] && !pending;
        swap     = !pending && !armed[act] && armed[~act];
        beat_done      = 2'b00;
        complete       = 2'b00;
        beat_done[act] = ack_fire;
        complete[act]  = finish;
    end

    // Outstanding-request flag and active-set pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            act     <= 1'b0;
        end else begin
            if (ack_fire) begin
                pending <= 1'b0;
            end else if (busy && per_ready && !pending) begin
                pending <= 1'b1;
            end
            if (swap) begin
                act <= ~act;
            end
        end
    end
endmodule

// File: rtl/pp_dma_ctrl.sv
// Control word: sticky per-set done flags with write-one-to-clear, the
// interrupt enable, and the level interrupt derived from them.
module pp_dma_ctrl
    import pp_dma_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [1:0]       complete,
    output logic [1:0]       done,
    output logic             irq_en,
    output logic             irq
);
    logic [1:0] clr;

    // Clear mask taken from the done-bit positions of the written word
    always_comb begin
        clr = ctrl_wr ? {wdata[CTRL_DONE1_BIT], wdata[CTRL_DONE0_BIT]} : 2'b00;
        irq = irq_en && (done != 2'b00);
    end

    // Done flags (set wins over clear) and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 2'b00;
            irq_en <= 1'b0;
        end else begin
            done <= (done & ~clr) | complete;
            if (ctrl_wr) begin
                irq_en <= wdata[CTRL_IE_BIT];
            end
        end
    end
endmodule

// File: rtl/pp_dma_chan.sv
// Ping-pong DMA channel top. Decodes the register bus, holds two
// descriptor sets, and routes data between the peripheral FIFO and memory
// in the direction fixed by DIR_TO_MEM. Assumes a word-aligned register
// bus (unaligned accesses are dropped) and a memory side that holds
// mem_ack for one cycle per beat.
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 32,
    parameter bit DIR_TO_MEM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              per_ready,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              per_pop,
    output logic [DATA_W-1:0] per_wdata,
    output logic              per_push,
    output logic              irq
);
    localparam int STEP = DATA_W / 8;

    logic [1:0]        blk;
    fld_e              fld;
    logic              aligned;
    logic [1:0]        set_wr;
    logic              ctrl_wr;
    logic [ADDR_W-1:0] set_addr [2];
    logic [LEN_W-1:0]  set_len  [2];
    logic [1:0]        armed;
    logic [1:0]        len_zero;
    logic [1:0]        beat_done;
    logic [1:0]        complete;
    logic [1:0]        done;
    logic              irq_en;
    logic              act;
    logic              pending;
    logic              ack_fire;

    // Address decode and write qualification (running active set locked)
    always_comb begin
        blk     = reg_addr[5:4];
        fld     = fld_e'(reg_addr[3:2]);
        aligned = (reg_addr[1:0] == 2'b00);
        ctrl_wr = reg_wr && aligned && (blk == BLK_CTRL);
        for (int s = 0; s < 2; s++) begin
            set_wr[s] = reg_wr && aligned && (blk == 2'(s))
                        && !(armed[s] && (act == s[0]));
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_set
        pp_dma_desc #(
            .ADDR_W(ADDR_W),
            .LEN_W (LEN_W),
            .REG_W (REG_W),
            .STEP  (STEP)
        ) u_desc (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (set_wr[s]),
            .wr_fld   (fld),
            .wdata    (reg_wdata),
            .beat_done(beat_done[s]),
            .clr_arm  (complete[s]),
            .cur_addr (set_addr[s]),
            .cur_len  (set_len[s]),
            .armed    (armed[s])
        );
        assign len_zero[s] = (set_len[s] == '0);
    end

    pp_dma_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .len_zero (len_zero),
        .per_ready(per_ready),
        .mem_ack  (mem_ack),
        .act      (act),
        .pending  (pending),
        .ack_fire (ack_fire),
        .beat_done(beat_done),
        .complete (complete)
    );

    pp_dma_ctrl #(
        .REG_W(REG_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata),
        .complete(complete),
        .done    (done),
        .irq_en  (irq_en),
        .irq     (irq)
    );

    // Memory-side request view of the active set
    assign mem_req   = pending;
    assign mem_addr  = set_addr[act];
    assign per_wdata = mem_rdata;

    if (DIR_TO_MEM) begin : g_to_mem
        assign mem_we    = 1'b1;
        assign mem_wdata = per_rdata;
        assign per_pop   = ack_fire;
        assign per_push  = 1'b0;
    end else begin : g_from_mem
        assign mem_we    = 1'b0;
        assign mem_wdata = '0;
        assign per_pop   = 1'b0;
        assign per_push  = ack_fire;
    end

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (aligned && (blk == BLK_SET0 || blk == BLK_SET1)) begin
            case (fld)
                FLD_ADDR: reg_rdata = REG_W'(set_addr[blk[0]]);
                FLD_LEN:  reg_rdata = REG_W'(set_len[blk[0]]);
                FLD_CMD:  reg_rdata[CMD_START_BIT] = armed[blk[0]];
                default:  reg_rdata = '0;
            endcase
        end else if (aligned && blk == BLK_CTRL && fld == FLD_ADDR) begin
            reg_rdata[CTRL_ACT_BIT]   = act;
            reg_rdata[CTRL_DONE0_BIT] = done[0];
            reg_rdata[CTRL_DONE1_BIT] = done[1];
            reg_rdata[CTRL_IE_BIT]    = irq_en;
        end
    end
endmodule

// File: rtl/pp_dma_chan_chk.sv
// Protocol checker for pp_dma_chan, attached by bind. Observes the memory
// handshake, the active-set pointer and the interrupt line.
module pp_dma_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              act,
    input logic [1:0]        armed,
    input logic              reg_wr,
    input logic [5:0]        reg_addr,
    input logic              irq
);
    // R3: an unacknowledged request stays up with the same address
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R4: an acknowledged beat moves the address by one word
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> mem_addr == $past(mem_addr) + ADDR_W'(STEP));

    // R6: requests only come from an armed active set
    assert_req_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> armed[act]);

    // R7: the active member changes only with no beat outstanding
    assert_flip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> !$past(mem_req));

    // R9: the interrupt only drops after a control-word write
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_wr && reg_addr[5:4] == 2'd2) |=> irq);
endmodule

bind pp_dma_chan pp_dma_chan_chk #(
    .ADDR_W(ADDR_W),
    .STEP  (DATA_W / 8)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .act     (act),
    .armed   (armed),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .irq     (irq)
);

// File: tb/pp_dma_chan_tb.sv
// Directed bench for pp_dma_chan (peripheral-to-memory direction).
module pp_dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        per_ready = 1'b0;
    logic [31:0] per_rdata = 32'hA000_0000;
    logic        per_pop, per_push;
    logic [31:0] per_wdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    int mem_lat = 0, wait_cnt = 0, stab_err = 0, pops = 0, log_n = 0;
    logic [31:0] held_addr = '0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [31:0] log_we   [64];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pp_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .per_ready(per_ready),
        .per_rdata(per_rdata), .per_pop(per_pop), .per_wdata(per_wdata),
        .per_push(per_push), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act_v, logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic reg_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ctrl(logic [31:0] mask);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            reg_read(6'h20, v);
            if ((v & mask) == mask) return;
        end
    endtask

    // Memory and peripheral stub: acknowledges after mem_lat waits, logs beats
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                per_rdata = per_rdata + 1;
            end else if (mem_req) begin
                if (wait_cnt > 0 && mem_addr !== held_addr) stab_err++;
                held_addr = mem_addr;
                if (wait_cnt >= mem_lat) begin
                    mem_ack = 1'b1;
                    wait_cnt = 0;
                    if (log_n < 64) begin
                        log_addr[log_n] = mem_addr;
                        log_data[log_n] = mem_wdata;
                        log_we[log_n]   = {31'b0, mem_we};
                    end
                    log_n++;
                    #1 if (per_pop) pops++;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 9; a++) begin
            reg_read(6'(a * 4), v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 mem_req", {31'b0, mem_req}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        reg_write(6'h10, 32'h0000_2468);
        reg_write(6'h14, 32'h0000_0007);
        reg_read(6'h10, v); check("R2 set1 addr", v, 32'h0000_2468);
        reg_read(6'h14, v); check("R2 set1 len", v, 32'h7);
        reg_read(6'h18, v); check("R2 set1 cmd idle", v, 32'h0);
        reg_read(6'h00, v); check("R2 set0 addr untouched", v, 32'h0);
        reg_write(6'h14, 32'h0);
    endtask

    task automatic t_single;
        logic [31:0] v, base;
        int first;
        reg_write(6'h20, 32'h8);
        reg_write(6'h00, 32'h0000_1000);
        reg_write(6'h04, 32'h4);
        first = log_n; base = per_rdata; pops = 0;
        per_ready = 1'b1;
        reg_write(6'h08, 32'h1);
        wait_ctrl(32'h2);
        check("R6 four beats", 32'(log_n - first), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R3 beat address", log_addr[first + i], 32'h1000 + 32'(4 * i));
            check("R5 beat data", log_data[first + i], base + 32'(i));
            check("R5 mem_we", log_we[first + i], 32'h1);
        end
        check("R5 pop strobes", 32'(pops), 32'd4);
        reg_read(6'h00, v); check("R4 final address", v, 32'h0000_1010);
        reg_read(6'h04, v); check("R4 final length", v, 32'h0);
        reg_read(6'h08, v); check("R6 start bit cleared", v, 32'h0);
        reg_read(6'h20, v); check("R9 done0 with enable", v, 32'hA);
        check("R9 irq raised", {31'b0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        check("R6 no beat after done", 32'(log_n - first), 32'd4);
    endtask

    task automatic t_pingpong;
        logic [31:0] v;
        int first;
        per_ready = 1'b0;
        mem_lat = 2;
        reg_write(6'h20, 32'hE);
        reg_write(6'h10, 32'h0000_2000);
        reg_write(6'h14, 32'h3);
        reg_write(6'h18, 32'h1);
        reg_read(6'h20, v); check("R7 set1 became active", v & 32'h1, 32'h1);
        reg_write(6'h00, 32'h0000_3000);
        reg_write(6'h04, 32'h2);
        reg_write(6'h08, 32'h1);
        reg_read(6'h00, v); check("R2 standby set0 writable", v, 32'h0000_3000);
        first = log_n;
        check("R3 no request without per_ready", {31'b0, mem_req}, 32'h0);
        per_ready = 1'b1;
        wait_ctrl(32'h6);
        check("R7 total beats", 32'(log_n - first), 32'd5);
        check("R7 beat0", log_addr[first],     32'h2000);
        check("R7 beat2", log_addr[first + 2], 32'h2008);
        check("R7 beat3", log_addr[first + 3], 32'h3000);
        check("R7 beat4", log_addr[first + 4], 32'h3004);
        check("R3 address held during wait", 32'(stab_err), 32'd0);
        reg_read(6'h20, v); check("R7 set0 active at end", v & 32'h1, 32'h0);
        mem_lat = 0;
    endtask

    task automatic t_locked;
        logic [31:0] v;
        int first;
        per_ready = 1'b0;
        reg_write(6'h20, 32'hE);
        reg_write(6'h00, 32'h0000_4000);
        reg_write(6'h04, 32'h2);
        reg_write(6'h08, 32'h1);
        reg_write(6'h00, 32'hDEAD_0000);
        reg_write(6'h04, 32'h9);
        reg_write(6'h08, 32'h0);
        reg_read(6'h00, v); check("R8 addr locked", v, 32'h0000_4000);
        reg_read(6'h04, v); check("R8 len locked", v, 32'h2);
        reg_read(6'h08, v); check("R8 start locked", v, 32'h1);
        reg_write(6'h10, 32'h0000_5000);
        reg_read(6'h10, v); check("R8 standby still writable", v, 32'h0000_5000);
        first = log_n;
        per_ready = 1'b1;
        wait_ctrl(32'h2);
        check("R8 beats of locked set", 32'(log_n - first), 32'd2);
        check("R8 first beat", log_addr[first], 32'h4000);
    endtask

    task automatic t_zero_len;
        logic [31:0] v;
        int first;
        reg_write(6'h20, 32'hE);
        first = log_n;
        reg_write(6'h10, 32'h0000_6000);
        reg_write(6'h14, 32'h0);
        reg_write(6'h18, 32'h1);
        wait_ctrl(32'h4);
        reg_read(6'h20, v); check("R10 done1 set", v & 32'h4, 32'h4);
        reg_read(6'h18, v); check("R10 start cleared", v, 32'h0);
        check("R10 no request", 32'(log_n - first), 32'd0);
        reg_read(6'h10, v); check("R10 address unchanged", v, 32'h0000_6000);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        check("R9 irq with done1", {31'b0, irq}, 32'h1);
        reg_write(6'h20, 32'h8);
        reg_read(6'h20, v); check("R9 zero bits do not clear", v & 32'h6, 32'h4);
        reg_write(6'h00, 32'h0000_7000);
        reg_write(6'h04, 32'h0);
        reg_write(6'h08, 32'h1);
        wait_ctrl(32'h6);
        reg_write(6'h20, 32'hC);
        reg_read(6'h20, v); check("R9 only done1 cleared", v & 32'h6, 32'h2);
        check("R9 irq held by done0", {31'b0, irq}, 32'h1);
        reg_write(6'h20, 32'h0);
        check("R9 enable off masks irq", {31'b0, irq}, 32'h0);
        reg_write(6'h20, 32'hA);
        reg_read(6'h20, v); check("R9 all clear", v & 32'hE, 32'h8);
        check("R9 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_single();
        t_pingpong();
        t_locked();
        t_zero_len();
        t_irq();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule